// File: doc/BRIEF.md
# Sixteen-bit arithmetic/logic unit with sign, zero, carry and overflow flags

This block is the execute stage of a small 16-bit little-endian processor. Each cycle it takes two operands, a 4-bit operation code and the current carry flag, and produces three things. The first is a 16-bit result. The second is a strobe telling the register file whether to store that result. The third is the flag set the operation produces. The arithmetic, logic and shift paths are purely combinational, so the result and the next flag value follow the inputs in the same cycle.

A four-bit flag register sits inside the block. It takes the next flag value on a rising clock edge when the flag write enable is high and the code is a defined operation. Carry is a plain input, so the surrounding core decides where it comes from, normally the stored carry bit. Subtraction follows the classic 8-bit convention: carry set means a borrow occurred. Compare and test produce flags only.

Data is offered on plain pins with no handshake. Nothing can stall an arithmetic step, so the block has no valid/ready pair and exerts no back-pressure. The caller sees the result in the same cycle it presents the operands.

Top module: `alu16_nzcv`

## Requirements
- R1: `result_o` is the 16-bit wrapped value of A+B (code 1), A-B (code 2), A+B+carry_i (code 3) and A-B-carry_i (code 4). `result_we_o` is high for codes 1-4 and 6-11.
- R2: For codes 1 and 3, flag C is the carry out of bit 15. For codes 2, 4 and 5, flag C is set exactly when the unsigned subtraction borrows. Code 4 also subtracts carry_i as a borrow.
- R3: For codes 1-5, flag V is set exactly when the signed two's-complement result lies outside -32768..32767.
- R4: For every defined code, flag N equals bit 15 of `result_o`. Flag Z is set exactly when all 16 bits of `result_o` are zero.
- R5: Code 6 gives A OR B, code 7 gives A AND B and code 8 gives A XOR B. For these codes V is 0 and C equals carry_i.
- R6: The shifts use operand A only and move it by one bit. Code 9 shifts left and fills bit 0 with zero. Code 10 shifts right and fills bit 15 with zero. Code 11 shifts right and copies bit 15 into itself. For all three, C takes the bit shifted out and V equals N XOR C.
- R7: Code 5 (compare) sets flags as code 2 does. Code 13 (test) sets flags from A AND B, with V=0 and C=carry_i. Both drive the computed value on `result_o` but hold `result_we_o` low.
- R8: Codes 0, 12, 14 and 15 do nothing. `result_o` is 0, `result_we_o` is 0, `nzcv_next_o` equals `nzcv_q_o`, and the flag register is not written even with `flag_we_i` high.
- R9: The flag register resets to 0 when `rst_ni` is low at a rising edge. It loads `nzcv_next_o` on a rising edge when `flag_we_i` is high and the code is defined, and holds otherwise.
- R10: Both flag ports order their bits as [3]=N, [2]=Z, [1]=C, [0]=V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Synchronous active-low reset of the flag register |
| opa_i | input | 16 | Operand A; the only operand the shifts use |
| opb_i | input | 16 | Operand B |
| op_i | input | 4 | Operation code |
| carry_i | input | 1 | Carry flag fed to the carry variants, and passed through by the logic ops |
| flag_we_i | input | 1 | Allows the flag register to load on this edge |
| result_o | output | 16 | Computed value |
| result_we_o | output | 1 | The destination register should store `result_o` |
| nzcv_next_o | output | 4 | Flag value produced by this operation |
| nzcv_q_o | output | 4 | Stored flag value |

## Verification
The bench builds the block with its default width of 16, so the signed and unsigned wrap points 0x7FFF, 0x8000 and 0xFFFF are directly reachable. Together with 0x0000 and the alternating patterns, they drive carry, borrow and overflow to both values on every arithmetic code. A sweep runs every 4-bit code, the unused ones included, against pairs of those edge operands with the carry input alternating. Interleaved steps with the flag write enable low show that the stored flags hold.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  // Operation codes; the numbering is fixed by the instruction encoding.
  typedef enum logic [3:0] {
    OP_NOP0 = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_ADC  = 4'd3,
    OP_SBC  = 4'd4,
    OP_CMP  = 4'd5,
    OP_OR   = 4'd6,
    OP_AND  = 4'd7,
    OP_XOR  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHRL = 4'd10,
    OP_SHRA = 4'd11,
    OP_TST  = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_OR  = 2'd0,
    LG_AND = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  typedef enum logic [1:0] {
    SH_LEFT   = 2'd0,
    SH_RLOGIC = 2'd1,
    SH_RARITH = 2'd2
  } shift_sel_e;

  typedef enum logic [1:0] {
    PATH_NONE  = 2'd0,
    PATH_ARITH = 2'd1,
    PATH_LOGIC = 2'd2,
    PATH_SHIFT = 2'd3
  } path_e;

  // Flag layout: [3]=N [2]=Z [1]=C [0]=V
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   total;

  // Subtraction is A + ~B + cin; cin is 1 for plain subtract and ~borrow for the chained form.
  assign b_eff = sub_i ? ~b_i : b_i;
  assign total = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o = total[MSB:0];
  // Carry flag means borrow on subtract, so invert the raw carry there.
  assign c_o   = sub_i ? ~total[W] : total[W];
  assign v_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_bitlogic.sv
`timescale 1ns/1ps
module alu_bitlogic
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LG_OR:   y_o[i] = a_i[i] | b_i[i];
        LG_AND:  y_o[i] = a_i[i] & b_i[i];
        LG_XOR:  y_o[i] = a_i[i] ^ b_i[i];
        default: y_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_shift1.sv
`timescale 1ns/1ps
module alu_shift1
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  shift_sel_e   sel_i,
  output logic [W-1:0] y_o,
  output logic         out_bit_o
);
  localparam int MSB = W - 1;

  always_comb begin
    unique case (sel_i)
      SH_LEFT: begin
        y_o       = {a_i[MSB-1:0], 1'b0};
        out_bit_o = a_i[MSB];
      end
      SH_RLOGIC: begin
        y_o       = {1'b0, a_i[MSB:1]};
        out_bit_o = a_i[0];
      end
      SH_RARITH: begin
        y_o       = {a_i[MSB], a_i[MSB:1]};
        out_bit_o = a_i[0];
      end
      default: begin
        y_o       = '0;
        out_bit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_flagreg.sv
`timescale 1ns/1ps
module alu_flagreg
  import alu_pkg::*;
#(
  parameter logic [3:0] RESET_VAL = 4'b0000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  nzcv_t d_i,
  output nzcv_t q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)   q_o <= nzcv_t'(RESET_VAL);
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu16_nzcv.sv
`timescale 1ns/1ps
module alu16_nzcv
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [3:0]   op_i,
  input  logic         carry_i,
  input  logic         flag_we_i,
  output logic [W-1:0] result_o,
  output logic         result_we_o,
  output logic [3:0]   nzcv_next_o,
  output logic [3:0]   nzcv_q_o
);
  localparam int MSB = W - 1;

  // Decode
  path_e      path;
  logic       writes;
  logic       is_sub;
  logic       add_cin;
  logic_sel_e lsel;
  shift_sel_e ssel;

  always_comb begin
    path    = PATH_NONE;
    writes  = 1'b0;
    is_sub  = 1'b0;
    add_cin = 1'b0;
    lsel    = LG_OR;
    ssel    = SH_LEFT;
    case (op_i)
      OP_ADD:  begin path = PATH_ARITH; writes = 1'b1; end
      OP_ADC:  begin path = PATH_ARITH; writes = 1'b1; add_cin = carry_i; end
      OP_SUB:  begin path = PATH_ARITH; writes = 1'b1; is_sub = 1'b1; add_cin = 1'b1; end
      OP_SBC:  begin path = PATH_ARITH; writes = 1'b1; is_sub = 1'b1; add_cin = ~carry_i; end
      OP_CMP:  begin path = PATH_ARITH; is_sub = 1'b1; add_cin = 1'b1; end
      OP_OR:   begin path = PATH_LOGIC; writes = 1'b1; lsel = LG_OR; end
      OP_AND:  begin path = PATH_LOGIC; writes = 1'b1; lsel = LG_AND; end
      OP_XOR:  begin path = PATH_LOGIC; writes = 1'b1; lsel = LG_XOR; end
      OP_TST:  begin path = PATH_LOGIC; lsel = LG_AND; end
      OP_SHL:  begin path = PATH_SHIFT; writes = 1'b1; ssel = SH_LEFT; end
      OP_SHRL: begin path = PATH_SHIFT; writes = 1'b1; ssel = SH_RLOGIC; end
      OP_SHRA: begin path = PATH_SHIFT; writes = 1'b1; ssel = SH_RARITH; end
      default: ;
    endcase
  end

  // Datapaths
  logic [W-1:0] arith_y, logic_y, shift_y;
  logic         arith_c, arith_v, shift_c;

  alu_addsub #(.W(W)) u_addsub (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sub_i (is_sub),
    .cin_i (add_cin),
    .sum_o (arith_y),
    .c_o   (arith_c),
    .v_o   (arith_v)
  );

  alu_bitlogic #(.W(W)) u_logic (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sel_i (lsel),
    .y_o   (logic_y)
  );

  alu_shift1 #(.W(W)) u_shift (
    .a_i       (opa_i),
    .sel_i     (ssel),
    .y_o       (shift_y),
    .out_bit_o (shift_c)
  );

  // Result select and flag formation
  nzcv_t flags_q, flags_d;
  logic [W-1:0] y;

  always_comb begin
    y       = '0;
    flags_d = flags_q;
    unique case (path)
      PATH_ARITH: begin
        y         = arith_y;
        flags_d.c = arith_c;
        flags_d.v = arith_v;
      end
      PATH_LOGIC: begin
        y         = logic_y;
        flags_d.c = carry_i;
        flags_d.v = 1'b0;
      end
      PATH_SHIFT: begin
        y         = shift_y;
        flags_d.c = shift_c;
        flags_d.v = shift_y[MSB] ^ shift_c;
      end
      default: ;
    endcase
    if (path != PATH_NONE) begin
      flags_d.n = y[MSB];
      flags_d.z = (y == '0);
    end
  end

  alu_flagreg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we_i && (path != PATH_NONE)),
    .d_i    (flags_d),
    .q_o    (flags_q)
  );

  assign result_o    = y;
  assign result_we_o = writes;
  assign nzcv_next_o = flags_d;
  assign nzcv_q_o    = flags_q;
endmodule

// File: rtl/alu16_nzcv_chk.sv
`timescale 1ns/1ps
module alu16_nzcv_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] opa_i,
  input logic [3:0]   op_i,
  input logic         flag_we_i,
  input logic [W-1:0] result_o,
  input logic         result_we_o,
  input logic [3:0]   nzcv_next_o,
  input logic [3:0]   nzcv_q_o
);
  logic defined_op, shift_op;
  assign defined_op = (op_i >= 4'd1 && op_i <= 4'd11) || (op_i == 4'd13);
  assign shift_op   = (op_i >= 4'd9 && op_i <= 4'd11);

  // R9: flags hold while writes are off
  a_r9_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(nzcv_q_o));

  // R9: flags load on an enabled defined operation
  a_r9_flags_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && defined_op) |=> (nzcv_q_o == $past(nzcv_next_o)));

  // R8: unused codes change nothing
  a_r8_unused_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !defined_op |-> (!result_we_o && nzcv_next_o == nzcv_q_o));

  // R8: unused codes leave the stored flags alone
  a_r8_unused_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !defined_op |=> $stable(nzcv_q_o));

  // R7: compare and test never write a register
  a_r7_no_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd5 || op_i == 4'd13) |-> !result_we_o);

  // R4: N and Z follow the result
  a_r4_sign_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defined_op |-> (nzcv_next_o[3] == result_o[W-1]));
  a_r4_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defined_op |-> (nzcv_next_o[2] == (result_o == '0)));

  // R6: shift overflow is N xor C
  a_r6_shift_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_op |-> (nzcv_next_o[0] == (nzcv_next_o[3] ^ nzcv_next_o[1])));

  // R6: the carry of a shift comes from operand A
  a_r6_shift_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_op |-> (nzcv_next_o[1] == ((op_i == 4'd9) ? opa_i[W-1] : opa_i[0])));
endmodule

bind alu16_nzcv alu16_nzcv_chk #(.W(W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .opa_i       (opa_i),
  .op_i        (op_i),
  .flag_we_i   (flag_we_i),
  .result_o    (result_o),
  .result_we_o (result_we_o),
  .nzcv_next_o (nzcv_next_o),
  .nzcv_q_o    (nzcv_q_o)
);

// File: tb/alu16_nzcv_tb_top.sv
`timescale 1ns/1ps
module alu16_nzcv_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [3:0]   op = 4'd0;
  logic         cin = 1'b0, fwe = 1'b0;
  logic [W-1:0] result;
  logic         result_we;
  logic [3:0]   nzcv_next, nzcv_q;

  always #10 clk = ~clk;  // 50 MHz

  alu16_nzcv #(.W(W)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .opa_i (opa), .opb_i (opb), .op_i (op),
    .carry_i (cin), .flag_we_i (fwe), .result_o (result), .result_we_o (result_we),
    .nzcv_next_o (nzcv_next), .nzcv_q_o (nzcv_q)
  );

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [3:0]  nxt;
    logic [3:0]  q;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [3:0] model_flags = 4'b0000;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic bit op_defined(input logic [3:0] o);
    return (o >= 4'd1 && o <= 4'd11) || (o == 4'd13);
  endfunction

  function automatic string tag_for(input logic [3:0] o);
    case (o)
      4'd1, 4'd2:        return "R1";
      4'd3, 4'd4:        return "R2";
      4'd5, 4'd13:       return "R7";
      4'd6, 4'd7, 4'd8:  return "R5";
      4'd9, 4'd10, 4'd11: return "R6";
      default:           return "R8";
    endcase
  endfunction

  // Reference model written from the requirements. Flag order: [3]=N [2]=Z [1]=C [0]=V (R10).
  task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [3:0] o,
                       input logic c_in, input logic [3:0] cur,
                       output logic [15:0] r, output logic we, output logic [3:0] f);
    logic [16:0] wide;
    int sa, sb, sv;
    logic c, v;
    sa = $signed(a);
    sb = $signed(b);
    r = 16'h0; c = 1'b0; v = 1'b0;
    we = (o >= 4'd1 && o <= 4'd4) || (o >= 4'd6 && o <= 4'd11);
    case (o)
      4'd1: begin wide = {1'b0, a} + {1'b0, b}; sv = sa + sb; end
      4'd3: begin wide = {1'b0, a} + {1'b0, b} + {16'h0, c_in}; sv = sa + sb + int'(c_in); end
      4'd2, 4'd5: begin wide = {1'b0, a} - {1'b0, b}; sv = sa - sb; end
      4'd4: begin wide = {1'b0, a} - {1'b0, b} - {16'h0, c_in}; sv = sa - sb - int'(c_in); end
      default: begin wide = '0; sv = 0; end
    endcase
    case (o)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5: begin
        r = wide[15:0]; c = wide[16]; v = (sv > 32767) || (sv < -32768);
      end
      4'd6: begin r = a | b; c = c_in; end
      4'd7, 4'd13: begin r = a & b; c = c_in; end
      4'd8: begin r = a ^ b; c = c_in; end
      4'd9:  begin r = {a[14:0], 1'b0}; c = a[15]; v = r[15] ^ c; end
      4'd10: begin r = {1'b0, a[15:1]}; c = a[0]; v = r[15] ^ c; end
      4'd11: begin r = {a[15], a[15:1]}; c = a[0]; v = r[15] ^ c; end
      default: ;
    endcase
    if (op_defined(o)) f = {r[15], (r == 16'h0), c, v};
    else               f = cur;
  endtask

  // Driver: apply one step, queue what must be seen
  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic [3:0] o,
                      input logic c_in, input logic we_flags, input string tag);
    exp_t e;
    @(negedge clk);
    opa = a; opb = b; op = o; cin = c_in; fwe = we_flags;
    model(a, b, o, c_in, model_flags, e.res, e.we, e.nxt);
    e.q   = model_flags;  // value loaded by earlier steps (R9)
    e.tag = tag;
    exp_q.push_back(e);
    if (we_flags && op_defined(o)) model_flags = e.nxt;
  endtask

  task automatic check4(input logic [15:0] act, input logic [15:0] expv,
                        input string tag, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Monitor: compare each queued item mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check4(result, e.res, e.tag, "result");
        check4({15'h0, result_we}, {15'h0, e.we}, e.tag, "result_we");
        check4({12'h0, nzcv_next}, {12'h0, e.nxt}, {e.tag, "/R10"}, "nzcv_next");
        check4({12'h0, nzcv_q}, {12'h0, e.q}, {e.tag, "/R9"}, "nzcv_q");
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [7];
    pats = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5555, 16'hAAAA};
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    check4({12'h0, nzcv_q}, 16'h0000, "R9", "reset flags");
    rst_n = 1'b1;

    // R1 / R3: signed overflow on add, wrap to zero with carry
    step(16'h7FFF, 16'h0001, 4'd1, 1'b0, 1'b1, "R3");
    step(16'hFFFF, 16'h0001, 4'd1, 1'b0, 1'b1, "R1");
    // R2: borrow on subtract, chained forms
    step(16'h0005, 16'h0007, 4'd2, 1'b0, 1'b1, "R2");
    step(16'h8000, 16'h0001, 4'd2, 1'b0, 1'b1, "R3");
    step(16'hFFFF, 16'h0000, 4'd3, 1'b1, 1'b1, "R2");
    step(16'h0000, 16'h0000, 4'd4, 1'b1, 1'b1, "R2");
    step(16'h0010, 16'h000F, 4'd4, 1'b1, 1'b1, "R2");
    // R7: compare equal, test zero
    step(16'h1234, 16'h1234, 4'd5, 1'b0, 1'b1, "R7");
    step(16'hF0F0, 16'h0F0F, 4'd13, 1'b1, 1'b1, "R7");
    // R5: logic ops pass carry through
    step(16'h8000, 16'h0001, 4'd6, 1'b0, 1'b1, "R5");
    step(16'h00FF, 16'h0F0F, 4'd7, 1'b1, 1'b1, "R5");
    step(16'hAAAA, 16'hAAAA, 4'd8, 1'b0, 1'b1, "R5");
    // R6: shifts on 0x8001 and 0x4000
    step(16'h8001, 16'hFFFF, 4'd9, 1'b0, 1'b1, "R6");
    step(16'h4000, 16'h0000, 4'd9, 1'b0, 1'b1, "R6");
    step(16'h8001, 16'h0000, 4'd10, 1'b0, 1'b1, "R6");
    step(16'h8001, 16'h0000, 4'd11, 1'b0, 1'b1, "R6");
    // R8: unused codes with flag writes enabled
    step(16'h0000, 16'h0000, 4'd0, 1'b1, 1'b1, "R8");
    step(16'hFFFF, 16'h0001, 4'd12, 1'b0, 1'b1, "R8");
    step(16'h8000, 16'h8000, 4'd14, 1'b1, 1'b1, "R8");
    step(16'h7FFF, 16'h7FFF, 4'd15, 1'b0, 1'b1, "R8");
    // R9: flag write disabled, register must hold
    step(16'h0000, 16'h0000, 4'd2, 1'b0, 1'b0, "R9");
    step(16'h8000, 16'h8000, 4'd1, 1'b0, 1'b0, "R9");
    step(16'h0001, 16'h0000, 4'd1, 1'b0, 1'b1, "R4");

    // Sweep: every code over edge pairs, carry alternating
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 7; i++) begin
        for (int j = 0; j < 7; j += 2) begin
          step(pats[i], pats[j], 4'(o), 1'((i + j + o) & 1), 1'((i + o) % 3 != 0),
               tag_for(4'(o)));
        end
      end
    end

    @(negedge clk);
    op = 4'd0; fwe = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule